// File: doc/BRIEF.md
# Preamplifier Fault Manager

This block collects the raw fault flags produced by a head preamplifier's analog sensing. It qualifies each flag by the operating mode and by three software inhibit bits, and encodes the active fault as a 4-bit code. It drives an active-high fault pin that follows the live condition. The code is held in a sticky status register until the operating-mode register is rewritten, which the block sees as a one-cycle clear strobe. For every fault it also decides whether write current must be cut.

A digital detector watches the write data input. It counts system clocks since the last write-data edge. When that count reaches a programmable limit, it reports a low-frequency fault. The limit is chosen so that it corresponds to a 1 MHz toggle rate at the system clock. The detector runs only in write mode.

Top module: `fm_fault_mgr`

## Requirements
- R1: The code register holds one of these values: 0 none, 1 write current present in read mode, 3 thermal asperity, 4 read head open, 5 no write current, 6 write data too slow, 7 write head open, 8 write head shorted. Value 2 is never produced.
- R2: `fault_pin` is high one clock after a qualified coded fault is present, and low one clock after none is present.
- R3: A nonzero code is held while the clear strobe is low, even if the condition goes away or other faults appear. When several faults become active in the same clock, the lowest code is captured.
- R4: One clock after `mode_clr` is high, the code reads 0. The next capture can happen in the following clock.
- R5: `wr_disable` rises one clock after any of these is present in write mode: no write current (raw bit 3), reference resistor fault (bit 6), supply low (bit 7) or illegal head address (bit 8). It never rises in read mode.
- R6: An open write head (bit 4), a shorted write head (bit 5) or slow write data does not raise `wr_disable`.
- R7: In write mode, with no edge on `wdata` for `lf_limit` clocks after an edge, code 6 becomes live. The pin rises 10 clocks after the toggle when `lf_limit` = 8. A toggle period shorter than the limit never raises the pin.
- R8: `inhibit[0]` masks thermal asperity (bit 1). `inhibit[1]` masks the slow-data detector. `inhibit[2]` masks no-write-current (bit 3) and its write disable.
- R9: Raw bits 0, 1 and 2 count only in read mode (`wr_mode` = 0). Raw bits 3, 4 and 5 and the slow-data detector count only in write mode.
- R10: After reset, `fault_pin` and `wr_disable` are 0 and the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_flags | input | 9 | Raw fault conditions, bit positions as in the requirements |
| wdata | input | 1 | Write data, synchronous to clk |
| wr_mode | input | 1 | 1 = write mode, 0 = read mode |
| inhibit | input | 3 | Detection inhibit bits |
| mode_clr | input | 1 | Strobe: operating-mode register was rewritten |
| lf_limit | input | CNT_W | Clocks without a write-data edge that count as too slow |
| fault_pin | output | 1 | Live fault indication |
| fault_code | output | 4 | Sticky fault code |
| wr_disable | output | 1 | Write current must be cut |

## Verification
The encoder is driven with single flags in both modes, with each flag inhibited, with two flags together, and with flags that carry only a write-disable action. Together these separate code mapping, mode gating, masking, priority and the disable rule. Directed sequences remove a condition after it has been latched and add a second fault on top of the first. They apply the clear while a condition persists, which tells the sticky code apart from the live pin. The slow-data detector is checked with a fast toggle, at the exact clock of its threshold, under inhibit, and on leaving write mode.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [3:0] {
    FC_NONE     = 4'd0,
    FC_WCUR_RD  = 4'd1,
    FC_TA       = 4'd3,
    FC_RD_OPEN  = 4'd4,
    FC_NO_WCUR  = 4'd5,
    FC_LOWFREQ  = 4'd6,
    FC_WR_OPEN  = 4'd7,
    FC_WR_SHORT = 4'd8
  } fcode_t;

  // coded conditions, index order = ascending code
  localparam int NCOND = 7;
  localparam int NRAW  = 9;

  function automatic fcode_t idx2code(input int idx);
    case (idx)
      0:       return FC_WCUR_RD;
      1:       return FC_TA;
      2:       return FC_RD_OPEN;
      3:       return FC_NO_WCUR;
      4:       return FC_LOWFREQ;
      5:       return FC_WR_OPEN;
      default: return FC_WR_SHORT;
    endcase
  endfunction
endpackage

// File: rtl/fm_slowdata.sv
module fm_slowdata #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdata,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             slow
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             wd_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             edge_seen;

  assign edge_seen = wdata ^ wd_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || edge_seen)
      cnt_d = '0;
    else if (cnt_q != CNT_MAX)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      wd_q  <= wdata;
      cnt_q <= cnt_d;
    end
  end

  assign slow = run && (cnt_q >= limit);
endmodule

// File: rtl/fm_prio.sv
module fm_prio
  import fm_pkg::*;
(
  input  logic [NCOND-1:0] live,
  output fcode_t           code
);
  always_comb begin
    code = FC_NONE;
    for (int i = NCOND - 1; i >= 0; i--) begin
      if (live[i]) code = idx2code(i);
    end
  end
endmodule

// File: rtl/fm_fault_mgr.sv
module fm_fault_mgr
  import fm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [8:0]       raw_flags,
  input  logic             wdata,
  input  logic             wr_mode,
  input  logic [2:0]       inhibit,
  input  logic             mode_clr,
  input  logic [CNT_W-1:0] lf_limit,
  output logic             fault_pin,
  output logic [3:0]       fault_code,
  output logic             wr_disable
);
  logic             rd_mode;
  logic             slow;
  logic [NCOND-1:0] live;
  fcode_t           new_code;
  fcode_t           code_q, code_d;
  logic             pin_q, pin_d;
  logic             dis_q, dis_d;
  logic             kill_req;

  assign rd_mode = !wr_mode;

  fm_slowdata #(.CNT_W(CNT_W)) u_slow (
    .clk   (clk),
    .rst_n (rst_n),
    .wdata (wdata),
    .run   (wr_mode && !inhibit[1]),
    .limit (lf_limit),
    .slow  (slow)
  );

  // qualified coded conditions, ascending code order
  always_comb begin
    live[0] = rd_mode && raw_flags[0];
    live[1] = rd_mode && raw_flags[1] && !inhibit[0];
    live[2] = rd_mode && raw_flags[2];
    live[3] = wr_mode && raw_flags[3] && !inhibit[2];
    live[4] = slow;
    live[5] = wr_mode && raw_flags[4];
    live[6] = wr_mode && raw_flags[5];
  end

  fm_prio u_prio (
    .live (live),
    .code (new_code)
  );

  assign kill_req = wr_mode && ((raw_flags[3] && !inhibit[2]) ||
                                raw_flags[6] || raw_flags[7] || raw_flags[8]);

  always_comb begin
    pin_d  = |live;
    dis_d  = kill_req;
    code_d = code_q;
    if (mode_clr)
      code_d = FC_NONE;
    else if (code_q == FC_NONE)
      code_d = new_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= FC_NONE;
      pin_q  <= 1'b0;
      dis_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      pin_q  <= pin_d;
      dis_q  <= dis_d;
    end
  end

  assign fault_pin  = pin_q;
  assign fault_code = code_q;
  assign wr_disable = dis_q;
endmodule

// File: rtl/fm_fault_mgr_chk.sv
module fm_fault_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_clr,
  input logic       wr_mode,
  input logic       fault_pin,
  input logic [3:0] fault_code,
  input logic       wr_disable
);
  // R1: only listed codes appear
  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 4'd2) && (fault_code <= 4'd8));

  // R3: a latched code holds while no clear is requested
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 4'd0) && !mode_clr |=> $stable(fault_code));

  // R4: clear empties the register
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clr |=> (fault_code == 4'd0));

  // R2: a raised pin without a preceding clear implies a captured code
  a_r2_pin_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_pin) && !$past(mode_clr) |-> (fault_code != 4'd0));

  // R5: write disable only follows write mode
  a_r5_disable_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> !wr_disable);
endmodule

bind fm_fault_mgr fm_fault_mgr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_clr   (mode_clr),
  .wr_mode    (wr_mode),
  .fault_pin  (fault_pin),
  .fault_code (fault_code),
  .wr_disable (wr_disable)
);

// File: tb/sim_fm_fault_mgr.sv
module sim_fm_fault_mgr;
  localparam int CNT_W = 16;
  localparam int NV = 18;

  logic             clk;
  logic             rst_n;
  logic [8:0]       raw_flags;
  logic             wdata;
  logic             wr_mode;
  logic [2:0]       inhibit;
  logic             mode_clr;
  logic [CNT_W-1:0] lf_limit;
  logic             fault_pin;
  logic [3:0]       fault_code;
  logic             wr_disable;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fm_fault_mgr #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .raw_flags(raw_flags), .wdata(wdata),
    .wr_mode(wr_mode), .inhibit(inhibit), .mode_clr(mode_clr),
    .lf_limit(lf_limit), .fault_pin(fault_pin), .fault_code(fault_code),
    .wr_disable(wr_disable)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {flags, wr_mode, inhibit, exp_pin, exp_dis, exp_code}
  typedef struct packed {
    logic [8:0] flags;
    logic       wr;
    logic [2:0] inh;
    logic       pin;
    logic       dis;
    logic [3:0] code;
  } vec_t;

  localparam vec_t VT [NV] = '{
    '{9'h000, 1'b0, 3'd0, 1'b0, 1'b0, 4'd0},  // R10 idle
    '{9'h001, 1'b0, 3'd0, 1'b1, 1'b0, 4'd1},  // R1
    '{9'h001, 1'b1, 3'd0, 1'b0, 1'b0, 4'd0},  // R9
    '{9'h002, 1'b0, 3'd0, 1'b1, 1'b0, 4'd3},  // R1
    '{9'h002, 1'b0, 3'd1, 1'b0, 1'b0, 4'd0},  // R8
    '{9'h004, 1'b0, 3'd0, 1'b1, 1'b0, 4'd4},  // R1
    '{9'h008, 1'b1, 3'd0, 1'b1, 1'b1, 4'd5},  // R5
    '{9'h008, 1'b1, 3'd4, 1'b0, 1'b0, 4'd0},  // R8
    '{9'h010, 1'b1, 3'd0, 1'b1, 1'b0, 4'd7},  // R6
    '{9'h020, 1'b1, 3'd0, 1'b1, 1'b0, 4'd8},  // R6
    '{9'h040, 1'b1, 3'd0, 1'b0, 1'b1, 4'd0},  // R5
    '{9'h080, 1'b1, 3'd0, 1'b0, 1'b1, 4'd0},  // R5
    '{9'h100, 1'b1, 3'd0, 1'b0, 1'b1, 4'd0},  // R5
    '{9'h040, 1'b0, 3'd0, 1'b0, 1'b0, 4'd0},  // R5 read mode
    '{9'h030, 1'b1, 3'd0, 1'b1, 1'b0, 4'd7},  // R3 lowest
    '{9'h006, 1'b0, 3'd0, 1'b1, 1'b0, 4'd3},  // R3 lowest
    '{9'h008, 1'b0, 3'd0, 1'b0, 1'b0, 4'd0},  // R9
    '{9'h03F, 1'b0, 3'd0, 1'b1, 1'b0, 4'd1}   // R9 write bits ignored
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; raw_flags = '0; wdata = 1'b0; wr_mode = 1'b0;
    inhibit = '0; mode_clr = 1'b0; lf_limit = 16'd200;
    repeat (3) @(negedge clk);
    chk("R10 pin", {3'b0, fault_pin}, 4'd0);
    chk("R10 dis", {3'b0, wr_disable}, 4'd0);
    chk("R10 code", fault_code, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      raw_flags = VT[i].flags; wr_mode = VT[i].wr; inhibit = VT[i].inh;
      wdata = ~wdata; mode_clr = 1'b1;
      @(negedge clk);
      mode_clr = 1'b0;
      chk("R4 clear", fault_code, 4'd0);
      @(negedge clk);
      chk("R2 pin", {3'b0, fault_pin}, {3'b0, VT[i].pin});
      chk("R5 dis", {3'b0, wr_disable}, {3'b0, VT[i].dis});
      chk("R1 code", fault_code, VT[i].code);
    end

    // R3 sticky after removal and first-detected holds
    raw_flags = 9'h000; wr_mode = 1'b0; inhibit = '0; mode_clr = 1'b1;
    @(negedge clk);
    mode_clr = 1'b0; raw_flags = 9'h004;
    @(negedge clk);
    chk("R3 capture", fault_code, 4'd4);
    raw_flags = 9'h005;
    @(negedge clk);
    chk("R3 first kept", fault_code, 4'd4);
    raw_flags = 9'h000;
    repeat (2) @(negedge clk);
    chk("R2 pin low", {3'b0, fault_pin}, 4'd0);
    chk("R3 sticky", fault_code, 4'd4);
    // R4 clear while condition persists: recapture next clock
    raw_flags = 9'h002; mode_clr = 1'b1;
    @(negedge clk);
    mode_clr = 1'b0;
    chk("R4 clr wins", fault_code, 4'd0);
    @(negedge clk);
    chk("R4 recapture", fault_code, 4'd3);

    // R7 slow write data detector
    raw_flags = '0; lf_limit = 16'd8; wr_mode = 1'b1; mode_clr = 1'b1;
    @(negedge clk);
    mode_clr = 1'b0;
    for (int k = 0; k < 12; k++) begin
      wdata = ~wdata;
      repeat (4) @(negedge clk);
    end
    chk("R7 fast ok", {3'b0, fault_pin}, 4'd0);
    chk("R7 fast code", fault_code, 4'd0);
    wdata = ~wdata;
    repeat (9) @(negedge clk);
    chk("R7 before limit", {3'b0, fault_pin}, 4'd0);
    @(negedge clk);
    chk("R7 at limit", {3'b0, fault_pin}, 4'd1);
    chk("R7 code", fault_code, 4'd6);
    chk("R6 slow no dis", {3'b0, wr_disable}, 4'd0);
    // R8 inhibit detector
    inhibit = 3'b010;
    repeat (2) @(negedge clk);
    chk("R8 slow inhibited", {3'b0, fault_pin}, 4'd0);
    inhibit = 3'b000;
    repeat (12) @(negedge clk);
    chk("R7 again", {3'b0, fault_pin}, 4'd1);
    // R9 leaving write mode stops detector
    wr_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 read no slow", {3'b0, fault_pin}, 4'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule